// File: doc/BRIEF.md
# Byte-Lane Synchronous RAM Port

This block is one synchronous access port onto an on-chip memory that is 36 bits wide, split into four 9-bit byte lanes. On each rising clock edge it decodes a pair of chip selects of opposite polarity, four active-low lane enables and a read/write strobe. From these it writes any subset of lanes at the presented address, or captures read data for any subset of lanes.

The output side models the high-impedance bus as one drive enable per lane. Undriven lanes also read back as zero on the data output. Two inputs act without waiting for a clock edge: an output-disable input and a sleep input. Either one turns off every lane at once. A mode input selects flow-through read data, valid in the cycle after the read edge, or pipelined read data, valid one cycle later. In pipelined mode the lane-enable pattern moves through the extra register together with the data.

Top module: `byte_lane_ram_port`

## Requirements
- R1: Lane k occupies data bits 9k to 9k+8 on both the write and read buses, and is controlled only by lane enable bit be_ni[k] (0 = lane enabled).
- R2: The port is selected only when ce0_ni is 0 and ce1_i is 1; with any other combination no lane is written and, after the read latency, no lane drives.
- R3: A selected write (we_ni = 0) updates exactly the enabled lanes at addr_i on the clock edge; the other lanes keep their previous contents.
- R4: In flow-through mode (pipe_mode_i = 0), a selected read (we_ni = 1) drives the enabled lanes with the stored data in the cycle after the edge; lanes that are not enabled have lane_drv_o = 0 and read as zero on rdata_o.
- R5: A selected access with all four lane enables high neither writes nor drives any lane.
- R6: While oe_ni is 1, lane_drv_o is 0 immediately, without a clock edge; when oe_ni returns to 0, the pending read lanes drive again.
- R7: While sleep_i is 1, no lane drives, and a write presented at a clock edge does not change the memory.
- R8: In pipelined mode (pipe_mode_i = 1), read data and its lane pattern appear one cycle later than in flow-through mode; in the cycle right after the read edge the lanes are still undriven.
- R9: While the inputs present a selected write, no lane drives, so the port never contends with incoming write data.
- R10: While rst_ni is 0, and right after it is released, all drive enables are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ce0_ni | input | 1 | Chip select, active low |
| ce1_i | input | 1 | Chip select, active high |
| be_ni | input | 4 | Lane enables, active low, bit k for lane k |
| we_ni | input | 1 | 0 = write, 1 = read |
| oe_ni | input | 1 | Asynchronous output disable when 1 |
| sleep_i | input | 1 | Asynchronous sleep, overrides all |
| pipe_mode_i | input | 1 | 0 = flow-through, 1 = pipelined read |
| addr_i | input | ADDR_W | Word address |
| wdata_i | input | 36 | Write data, four 9-bit lanes |
| rdata_o | output | 36 | Read data, zero on undriven lanes |
| lane_drv_o | output | 4 | Per-lane drive enable (0 = high impedance) |

## Verification
Writes with full, single-lane and paired-lane masks are read back with masks that differ from the write masks, so a lane that leaks or is swapped shows up as a wrong 9-bit field. Reads are run in both latency modes: a pipelined read must be silent in the cycle where a flow-through read would already drive, which separates the two latencies. Deselect patterns on each chip select alone, an empty lane mask, and writes under sleep are each followed by a readback of the earlier contents. The output-disable, sleep and write-presentation overrides are toggled in the middle of a cycle, so that the test tells an asynchronous cutoff apart from a registered one.

// File: rtl/brp_pkg.sv
`timescale 1ns/1ps
package brp_pkg;
  localparam int unsigned LANES  = 4;
  localparam int unsigned LANE_W = 9;
  localparam int unsigned DATA_W = LANES * LANE_W;
  typedef logic [LANES-1:0]  lane_mask_t;
  typedef logic [DATA_W-1:0] word_t;
endpackage

// File: rtl/brp_decode.sv
`timescale 1ns/1ps
module brp_decode
  import brp_pkg::*;
(
  input  logic       ce0_ni,
  input  logic       ce1_i,
  input  lane_mask_t be_ni,
  input  logic       we_ni,
  input  logic       sleep_i,
  output lane_mask_t wr_lanes_o,
  output lane_mask_t rd_lanes_o,
  output logic       wr_busy_o
);
  logic       sel;
  lane_mask_t act;

  assign sel        = ~ce0_ni & ce1_i & ~sleep_i;
  assign act        = sel ? ~be_ni : '0;
  assign wr_lanes_o = we_ni ? '0 : act;
  assign rd_lanes_o = we_ni ? act : '0;
  // a presented write mutes the bus even before its edge
  assign wr_busy_o  = ~ce0_ni & ce1_i & ~we_ni;
endmodule

// File: rtl/brp_lanes.sv
`timescale 1ns/1ps
module brp_lanes
  import brp_pkg::*;
#(
  parameter int unsigned ADDR_W = 6
) (
  input  logic              clk_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  word_t             wdata_i,
  input  lane_mask_t        wr_lanes_i,
  input  lane_mask_t        rd_lanes_i,
  output word_t             rdata_o
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];
    logic [LANE_W-1:0] rd_q;

    always_ff @(posedge clk_i) begin
      if (wr_lanes_i[l]) mem[addr_i] <= wdata_i[l*LANE_W +: LANE_W];
      if (rd_lanes_i[l]) rd_q <= mem[addr_i];
    end

    assign rdata_o[l*LANE_W +: LANE_W] = rd_q;
  end
endmodule

// File: rtl/brp_outstage.sv
`timescale 1ns/1ps
module brp_outstage
  import brp_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       pipe_i,
  input  logic       oe_ni,
  input  logic       sleep_i,
  input  logic       wr_busy_i,
  input  lane_mask_t rd_lanes_i,
  input  word_t      rdata_i,
  output word_t      rdata_o,
  output lane_mask_t lane_drv_o
);
  lane_mask_t lane_q1, lane_q2, lane_sel;
  word_t      data_q2, data_sel;
  logic       en_all;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lane_q1 <= '0;
      lane_q2 <= '0;
    end else begin
      lane_q1 <= rd_lanes_i;
      lane_q2 <= lane_q1;
    end
  end

  always_ff @(posedge clk_i) data_q2 <= rdata_i;

  assign lane_sel = pipe_i ? lane_q2 : lane_q1;
  assign data_sel = pipe_i ? data_q2 : rdata_i;
  assign en_all   = ~oe_ni & ~sleep_i & ~wr_busy_i;

  for (genvar l = 0; l < LANES; l++) begin : g_drv
    assign lane_drv_o[l] = lane_sel[l] & en_all;
    assign rdata_o[l*LANE_W +: LANE_W] =
      lane_drv_o[l] ? data_sel[l*LANE_W +: LANE_W] : '0;
  end
endmodule

// File: rtl/byte_lane_ram_port.sv
`timescale 1ns/1ps
module byte_lane_ram_port
  import brp_pkg::*;
#(
  parameter int unsigned ADDR_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ce0_ni,
  input  logic              ce1_i,
  input  logic [3:0]        be_ni,
  input  logic              we_ni,
  input  logic              oe_ni,
  input  logic              sleep_i,
  input  logic              pipe_mode_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [35:0]       wdata_i,
  output logic [35:0]       rdata_o,
  output logic [3:0]        lane_drv_o
);
  lane_mask_t wr_lanes, rd_lanes;
  logic       wr_busy;
  word_t      arr_rdata;

  brp_decode u_decode (
    .ce0_ni     (ce0_ni),
    .ce1_i      (ce1_i),
    .be_ni      (be_ni),
    .we_ni      (we_ni),
    .sleep_i    (sleep_i),
    .wr_lanes_o (wr_lanes),
    .rd_lanes_o (rd_lanes),
    .wr_busy_o  (wr_busy)
  );

  brp_lanes #(.ADDR_W(ADDR_W)) u_lanes (
    .clk_i      (clk_i),
    .addr_i     (addr_i),
    .wdata_i    (wdata_i),
    .wr_lanes_i (wr_lanes),
    .rd_lanes_i (rd_lanes),
    .rdata_o    (arr_rdata)
  );

  brp_outstage u_out (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pipe_i     (pipe_mode_i),
    .oe_ni      (oe_ni),
    .sleep_i    (sleep_i),
    .wr_busy_i  (wr_busy),
    .rd_lanes_i (rd_lanes),
    .rdata_i    (arr_rdata),
    .rdata_o    (rdata_o),
    .lane_drv_o (lane_drv_o)
  );
endmodule

// File: rtl/brp_checker.sv
`timescale 1ns/1ps
module brp_checker (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        ce0_ni,
  input logic        ce1_i,
  input logic [3:0]  be_ni,
  input logic        we_ni,
  input logic        oe_ni,
  input logic        sleep_i,
  input logic        pipe_mode_i,
  input logic [35:0] rdata_o,
  input logic [3:0]  lane_drv_o
);
  logic [35:0] drv_bits;
  always_comb
    for (int l = 0; l < 4; l++) drv_bits[l*9 +: 9] = {9{lane_drv_o[l]}};

  AST_SLEEP_HIZ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleep_i |-> lane_drv_o == 4'b0); // R7
  AST_OE_HIZ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_ni |-> lane_drv_o == 4'b0); // R6
  AST_WRITE_HIZ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ce0_ni && ce1_i && !we_ni) |-> lane_drv_o == 4'b0); // R9
  AST_DESEL_FLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((ce0_ni || !ce1_i) && !pipe_mode_i) |=> (pipe_mode_i || lane_drv_o == 4'b0)); // R2
  AST_BE_SUBSET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ce0_ni && ce1_i && we_ni && !pipe_mode_i)
      |=> (pipe_mode_i || (lane_drv_o & $past(be_ni)) == 4'b0)); // R4
  AST_UNDRIVEN_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rdata_o & ~drv_bits) == 36'b0); // R4
endmodule

bind byte_lane_ram_port brp_checker u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .ce0_ni      (ce0_ni),
  .ce1_i       (ce1_i),
  .be_ni       (be_ni),
  .we_ni       (we_ni),
  .oe_ni       (oe_ni),
  .sleep_i     (sleep_i),
  .pipe_mode_i (pipe_mode_i),
  .rdata_o     (rdata_o),
  .lane_drv_o  (lane_drv_o)
);

// File: tb/byte_lane_ram_port_tb.sv
`timescale 1ns/1ps
module byte_lane_ram_port_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        ce0_ni = 1'b1, ce1_i = 1'b0, we_ni = 1'b1;
  logic        oe_ni = 1'b0, sleep_i = 1'b0, pipe_mode_i = 1'b0;
  logic [3:0]  be_ni = 4'hF;
  logic [5:0]  addr_i = '0;
  logic [35:0] wdata_i = '0;
  logic [35:0] rdata_o;
  logic [3:0]  lane_drv_o;
  int          checks = 0, errors = 0;
  logic        done = 1'b0;

  always #2 clk_i = ~clk_i;

  byte_lane_ram_port u_dut (.*);

  typedef struct packed {
    logic        pipe;
    logic        ce0_n;
    logic        ce1;
    logic [3:0]  be_n;
    logic        we_n;
    logic [5:0]  addr;
    logic [35:0] wdata;
    logic [3:0]  exp_drv;
    logic [35:0] exp_data;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    '{1'b0,1'b0,1'b1,4'b0000,1'b0,6'd1,36'h123456789,4'h0,36'h0,4'd3},         // R3 full write
    '{1'b0,1'b0,1'b1,4'b0000,1'b1,6'd1,36'h0,4'hF,36'h123456789,4'd4},         // R4 full read
    '{1'b0,1'b0,1'b1,4'b1110,1'b0,6'd1,36'hFFFFFFFFF,4'h0,36'h0,4'd3},         // R3 lane 0 write
    '{1'b0,1'b0,1'b1,4'b0000,1'b1,6'd1,36'h0,4'hF,36'h1234567FF,4'd3},         // R3 readback
    '{1'b0,1'b0,1'b1,4'b0000,1'b0,6'd2,36'h0,4'h0,36'h0,4'd3},                 // R3 clear
    '{1'b0,1'b0,1'b1,4'b0011,1'b0,6'd2,36'hFFFFFFFFF,4'h0,36'h0,4'd1},         // R1 upper lanes
    '{1'b0,1'b0,1'b1,4'b1100,1'b1,6'd2,36'h0,4'b0011,36'h0,4'd4},              // R4 lower read
    '{1'b0,1'b0,1'b1,4'b1010,1'b1,6'd2,36'h0,4'b0101,36'h007FC0000,4'd1},      // R1 lanes 0,2
    '{1'b1,1'b0,1'b1,4'b0000,1'b1,6'd2,36'h0,4'hF,36'hFFFFC0000,4'd8},         // R8 pipe full
    '{1'b1,1'b0,1'b1,4'b0111,1'b1,6'd1,36'h0,4'b1000,36'h120000000,4'd8},      // R8 pipe lane 3
    '{1'b0,1'b1,1'b1,4'b0000,1'b1,6'd1,36'h0,4'h0,36'h0,4'd2},                 // R2 ce0 high
    '{1'b0,1'b0,1'b0,4'b0000,1'b1,6'd1,36'h0,4'h0,36'h0,4'd2},                 // R2 ce1 low
    '{1'b0,1'b0,1'b1,4'b1111,1'b1,6'd1,36'h0,4'h0,36'h0,4'd5},                 // R5 empty read
    '{1'b0,1'b1,1'b0,4'b0000,1'b0,6'd1,36'h0,4'h0,36'h0,4'd2},                 // R2 deselected write
    '{1'b0,1'b0,1'b1,4'b1111,1'b0,6'd1,36'h0,4'h0,36'h0,4'd5},                 // R5 empty write
    '{1'b0,1'b0,1'b1,4'b0000,1'b1,6'd1,36'h0,4'hF,36'h1234567FF,4'd2}          // R2 R5 unchanged
  };

  task automatic check(input string req, input logic [35:0] got, input logic [35:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic idle();
    ce0_ni = 1'b1; ce1_i = 1'b0; we_ni = 1'b1; be_ni = 4'hF; wdata_i = '0;
  endtask

  task automatic access(input logic c0, input logic c1, input logic [3:0] be,
                        input logic we, input logic [5:0] a, input logic [35:0] d);
    ce0_ni = c0; ce1_i = c1; be_ni = be; we_ni = we; addr_i = a; wdata_i = d;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog got=running exp=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    idle();
    #1;
    check("R10 reset drive", {32'b0, lane_drv_o}, 36'h0);
    check("R10 reset data", rdata_o, 36'h0);
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    #0.4;
    check("R10 after release", {32'b0, lane_drv_o}, 36'h0);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk_i);
      pipe_mode_i = VECS[i].pipe;
      access(VECS[i].ce0_n, VECS[i].ce1, VECS[i].be_n, VECS[i].we_n,
             VECS[i].addr, VECS[i].wdata);
      @(negedge clk_i);
      idle();
      #0.4;
      if (VECS[i].pipe) begin
        check("R8 pipe early silent", {32'b0, lane_drv_o}, 36'h0);
        @(negedge clk_i);
        #0.4;
      end
      check($sformatf("R%0d vec%0d drive", VECS[i].req, i), {32'b0, lane_drv_o},
            {32'b0, VECS[i].exp_drv});
      check($sformatf("R%0d vec%0d data", VECS[i].req, i), rdata_o, VECS[i].exp_data);
    end
    pipe_mode_i = 1'b0;

    // R6: asynchronous output disable
    @(negedge clk_i); access(1'b0, 1'b1, 4'h0, 1'b1, 6'd1, '0);
    @(negedge clk_i); idle();
    #0.4; check("R6 before disable", {32'b0, lane_drv_o}, 36'hF);
    oe_ni = 1'b1;
    #0.4; check("R6 disabled drive", {32'b0, lane_drv_o}, 36'h0);
    check("R6 disabled data", rdata_o, 36'h0);
    oe_ni = 1'b0;
    #0.4; check("R6 re-enabled", rdata_o, 36'h1234567FF);

    // R9: presenting a write mutes the bus before its edge
    @(negedge clk_i); access(1'b0, 1'b1, 4'h0, 1'b1, 6'd2, '0);
    @(negedge clk_i); access(1'b0, 1'b1, 4'h0, 1'b0, 6'd3, 36'hABCDEF012);
    #0.4; check("R9 write presented", {32'b0, lane_drv_o}, 36'h0);
    idle();
    #0.4; check("R9 after write removed", rdata_o, 36'hFFFFC0000);

    // R7: sleep mutes and blocks writes
    @(negedge clk_i); access(1'b0, 1'b1, 4'h0, 1'b1, 6'd1, '0);
    @(negedge clk_i); idle();
    sleep_i = 1'b1;
    #0.4; check("R7 sleep drive", {32'b0, lane_drv_o}, 36'h0);
    @(negedge clk_i); access(1'b0, 1'b1, 4'h0, 1'b0, 6'd1, 36'h0);
    @(negedge clk_i); idle(); sleep_i = 1'b0;
    @(negedge clk_i); access(1'b0, 1'b1, 4'h0, 1'b1, 6'd1, '0);
    @(negedge clk_i); idle();
    #0.4; check("R7 contents kept", rdata_o, 36'h1234567FF);

    // R10: reset in the middle of a read
    @(negedge clk_i); access(1'b0, 1'b1, 4'h0, 1'b1, 6'd1, '0);
    @(negedge clk_i); idle();
    rst_ni = 1'b0;
    #0.4; check("R10 reset mid read", {32'b0, lane_drv_o}, 36'h0);
    rst_ni = 1'b1;

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule